// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits between an 8-bit processor bus (16-bit address, 8-bit data, separate read and write strobes) and an external program ROM and a battery-backed work RAM. Processor writes that land in the ROM address range never reach the ROM. Instead they load three configuration registers: a RAM access enable, a 7-bit ROM bank number and a 2-bit RAM bank number. Unsupported RAM-select codes leave the RAM bank unchanged and raise a sticky error flag.

From these registers the block turns every processor address into a physical address. The lower 16 KiB of the map always shows ROM bank 0. The upper 16 KiB shows the selected bank. The 8 KiB RAM window shows the selected RAM bank. Both physical addresses wrap to the parameterised ROM and RAM sizes. The block also returns read data to the processor, chosen from ROM, from RAM, or as an open-bus value, and it drives the RAM write enable only while RAM is enabled and fitted.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset, RAM access is off, the effective ROM bank is 1, the RAM bank is 0 and `selErr` is low.
- R2: A write to 0x0000–0x1FFF turns RAM access on when data bits [3:0] equal 0xA. Any other value in those bits turns it off.
- R3: A write to 0x2000–0x3FFF stores data bits [6:0] as the ROM bank, and data bit 7 is ignored. A stored value of 0 acts as bank 1.
- R4: A read address in 0x0000–0x3FFF puts address bits [13:0] on `romAddr`, with all higher bits zero.
- R5: A read address in 0x4000–0x7FFF gives `romAddr` = (effective bank mod ROM_BANKS) × 0x4000 + address bits [13:0].
- R6: A write to 0x4000–0x5FFF with a value from 0x00 to 0x03 makes that value the RAM bank.
- R7: A write to 0x4000–0x5FFF with any value above 0x03, including the clock-select codes 0x08–0x0C, leaves the RAM bank unchanged and sets `selErr`. Once set, `selErr` stays high until reset.
- R8: A write to 0x6000–0x7FFF changes no register.
- R9: An address in 0xA000–0xBFFF gives `ramAddr` = (RAM bank mod number of 8 KiB banks) × 0x2000 + address bits [12:0].
- R10: When RAM access is off, or RAM_KB is 0, a read in 0xA000–0xBFFF returns 0xFF and `ramWe` stays low for a write there.
- R11: With `cpuRd` high, `cpuRdData` carries `romData` for addresses below 0x8000. It carries `ramRdData` for enabled RAM window accesses and 0xFF everywhere else. With `cpuRd` low it is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cpuAddr | input | 16 | Processor address |
| cpuWrData | input | 8 | Processor write data |
| cpuWr | input | 1 | Processor write strobe, sampled at the clock edge |
| cpuRd | input | 1 | Processor read strobe |
| romData | input | 8 | Data returned by the external ROM |
| ramRdData | input | 8 | Data returned by the external RAM |
| romAddr | output | 14+log2(ROM_BANKS) | Physical ROM byte address |
| ramAddr | output | 13+log2(RAM banks) | Physical RAM byte address |
| ramWe | output | 1 | RAM write enable |
| cpuRdData | output | 8 | Read data returned to the processor |
| selErr | output | 1 | Sticky flag for an unsupported RAM-select write |

## Verification
A seeded random stream mixes writes to all four register regions with reads and writes across the whole address map. Each access is compared against a bench-side register model, which separates correct region decoding from crosstalk between registers.

Directed cases cover the ROM bank corner cases:
- a stored bank of 0, and a write of 0x80, both of which must act as bank 1;
- banks above ROM_BANKS, which must wrap back onto low banks.

Further directed cases cover:
- enable values whose high nibble is non-zero, which still enable RAM;
- clock-select and out-of-range RAM selects, which leave the RAM bank unchanged and set `selErr`;
- the latch region, which changes no register.

Reads with the strobe low, and reads outside both windows, show the open-bus value apart from real data.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  // Configuration handed from the register block to the address datapath
  typedef struct packed {
    logic       ramOn;
    logic [6:0] romBank;   // effective bank, never zero
    logic [1:0] ramBank;
  } bankCfg_t;

  localparam logic [7:0] OPEN_BUS = 8'hFF;
  localparam int unsigned ROM_BANK_BYTES_LOG2 = 14;
  localparam int unsigned RAM_BANK_BYTES_LOG2 = 13;

endpackage

// File: rtl/cart_bank_ctl.sv
module cart_bank_ctl
  import cart_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [15:0] cpuAddr,
  input  logic [7:0]  cpuWrData,
  input  logic        cpuWr,
  output bankCfg_t    cfg,
  output logic        selErr
);

  typedef enum logic [1:0] {
    REG_RAM_ON  = 2'd0,
    REG_ROM_BNK = 2'd1,
    REG_RAM_SEL = 2'd2,
    REG_LATCH   = 2'd3
  } regSel_e;

  logic       ramOnQ;
  logic [6:0] romBankQ;
  logic [1:0] ramBankQ;
  logic       selErrQ;
  logic       regWr;
  logic       selOk;
  regSel_e    regSel;
  logic       unusedCtl;

  assign regWr  = cpuWr && !cpuAddr[15];
  assign regSel = regSel_e'(cpuAddr[14:13]);
  assign selOk  = (cpuWrData <= 8'h03);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ramOnQ   <= 1'b0;
      romBankQ <= 7'd1;
      ramBankQ <= 2'd0;
      selErrQ  <= 1'b0;
    end else if (regWr) begin
      unique case (regSel)
        REG_RAM_ON:  ramOnQ   <= (cpuWrData[3:0] == 4'hA);
        REG_ROM_BNK: romBankQ <= cpuWrData[6:0];
        REG_RAM_SEL: begin
          if (selOk) ramBankQ <= cpuWrData[1:0];
          else       selErrQ  <= 1'b1;
        end
        REG_LATCH:   ;
        default:     ;
      endcase
    end
  end

  always_comb begin
    cfg.ramOn   = ramOnQ;
    cfg.romBank = (romBankQ == 7'd0) ? 7'd1 : romBankQ;
    cfg.ramBank = ramBankQ;
  end

  assign selErr    = selErrQ;
  assign unusedCtl = ^{cpuAddr[12:0]};

  // R2
  ram_on_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr[15:13] == 3'b000 && cpuWrData[3:0] == 4'hA) |=> cfg.ramOn);

  // R6
  ram_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr[15:13] == 3'b010 && cpuWrData <= 8'h03)
      |=> cfg.ramBank == $past(cpuWrData[1:0]));

  // R7
  bad_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr[15:13] == 3'b010 && cpuWrData > 8'h03)
      |=> ($stable(cfg.ramBank) && selErr));

  // R7
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    selErr |=> selErr);

  // R8
  latch_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWr && cpuAddr[15:13] == 3'b011) |=> $stable(cfg));

endmodule

// File: rtl/cart_bank_dp.sv
module cart_bank_dp
  import cart_bank_pkg::*;
#(
  parameter int unsigned ROM_BANKS = 32,
  parameter int unsigned RAM_KB    = 32,
  localparam int unsigned RAM_BANKS = RAM_KB / 8,
  localparam int unsigned ROM_BW = (ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 0,
  localparam int unsigned RAM_BW = (RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 0,
  localparam int unsigned ROM_AW = ROM_BANK_BYTES_LOG2 + ROM_BW,
  localparam int unsigned RAM_AW = RAM_BANK_BYTES_LOG2 + RAM_BW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cpuAddr,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  bankCfg_t          cfg,
  input  logic [7:0]        romData,
  input  logic [7:0]        ramRdData,
  output logic [ROM_AW-1:0] romAddr,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramWe,
  output logic [7:0]        cpuRdData
);

  localparam logic HAS_RAM = (RAM_KB != 0);

  logic inRom;
  logic inRam;
  logic ramAccess;
  logic unusedDp;

  assign inRom     = !cpuAddr[15];
  assign inRam     = (cpuAddr[15:13] == 3'b101);
  assign ramAccess = inRam && cfg.ramOn && HAS_RAM;

  generate
    if (ROM_BW > 0) begin : g_romBanked
      logic [ROM_BW-1:0] romHi;
      assign romHi   = cpuAddr[14] ? cfg.romBank[ROM_BW-1:0] : '0;
      assign romAddr = {romHi, cpuAddr[13:0]};
    end else begin : g_romFlat
      assign romAddr = cpuAddr[13:0];
    end

    if (RAM_BW > 0) begin : g_ramBanked
      assign ramAddr = {cfg.ramBank[RAM_BW-1:0], cpuAddr[12:0]};
    end else begin : g_ramFlat
      assign ramAddr = cpuAddr[12:0];
    end
  endgenerate

  assign ramWe = cpuWr && ramAccess;

  always_comb begin
    if (!cpuRd)         cpuRdData = OPEN_BUS;
    else if (inRom)     cpuRdData = romData;
    else if (ramAccess) cpuRdData = ramRdData;
    else                cpuRdData = OPEN_BUS;
  end

  assign unusedDp = ^{cpuAddr, cfg};

  // R10
  ram_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (cfg.ramOn && cpuAddr[15:13] == 3'b101));

  // R10
  open_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRd && cpuAddr[15:13] == 3'b101 && !cfg.ramOn) |-> cpuRdData == 8'hFF);

  // R11
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cpuRd |-> cpuRdData == 8'hFF);

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
  import cart_bank_pkg::*;
#(
  parameter int unsigned ROM_BANKS = 32,
  parameter int unsigned RAM_KB    = 32,
  localparam int unsigned RAM_BANKS = RAM_KB / 8,
  localparam int unsigned ROM_AW = ROM_BANK_BYTES_LOG2 + ((ROM_BANKS > 1) ? $clog2(ROM_BANKS) : 0),
  localparam int unsigned RAM_AW = RAM_BANK_BYTES_LOG2 + ((RAM_BANKS > 1) ? $clog2(RAM_BANKS) : 0)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [15:0]       cpuAddr,
  input  logic [7:0]        cpuWrData,
  input  logic              cpuWr,
  input  logic              cpuRd,
  input  logic [7:0]        romData,
  input  logic [7:0]        ramRdData,
  output logic [ROM_AW-1:0] romAddr,
  output logic [RAM_AW-1:0] ramAddr,
  output logic              ramWe,
  output logic [7:0]        cpuRdData,
  output logic              selErr
);

  bankCfg_t cfg;

  cart_bank_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .cpuAddr   (cpuAddr),
    .cpuWrData (cpuWrData),
    .cpuWr     (cpuWr),
    .cfg       (cfg),
    .selErr    (selErr)
  );

  cart_bank_dp #(
    .ROM_BANKS (ROM_BANKS),
    .RAM_KB    (RAM_KB)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cpuAddr   (cpuAddr),
    .cpuRd     (cpuRd),
    .cpuWr     (cpuWr),
    .cfg       (cfg),
    .romData   (romData),
    .ramRdData (ramRdData),
    .romAddr   (romAddr),
    .ramAddr   (ramAddr),
    .ramWe     (ramWe),
    .cpuRdData (cpuRdData)
  );

endmodule

// File: tb/cart_bank_ctrl_bench.sv
module cart_bank_ctrl_bench;

  localparam int ROM_BANKS = 32;
  localparam int RAM_KB    = 32;
  localparam int RAM_BANKS = RAM_KB / 8;
  localparam int ROM_AW    = 14 + $clog2(ROM_BANKS);
  localparam int RAM_AW    = 13 + $clog2(RAM_BANKS);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [15:0]       cpuAddr = '0;
  logic [7:0]        cpuWrData = '0;
  logic              cpuWr = 1'b0;
  logic              cpuRd = 1'b0;
  logic [7:0]        romData = '0;
  logic [7:0]        ramRdData = '0;
  logic [ROM_AW-1:0] romAddr;
  logic [RAM_AW-1:0] ramAddr;
  logic              ramWe;
  logic [7:0]        cpuRdData;
  logic              selErr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench register model
  bit mOn;
  int mBank;
  int mRamBank;
  bit mErr;

  always #5 clk = ~clk;

  cart_bank_ctrl #(.ROM_BANKS(ROM_BANKS), .RAM_KB(RAM_KB)) u_cart_bank_ctrl (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWrData(cpuWrData),
    .cpuWr(cpuWr), .cpuRd(cpuRd), .romData(romData), .ramRdData(ramRdData),
    .romAddr(romAddr), .ramAddr(ramAddr), .ramWe(ramWe),
    .cpuRdData(cpuRdData), .selErr(selErr)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int expRom(int a);
    int eff;
    eff = (mBank == 0) ? 1 : mBank;
    if (a < 16'h4000) return a & 16'h3FFF;
    return (eff % ROM_BANKS) * 16384 + (a & 16'h3FFF);
  endfunction

  function automatic int expRam(int a);
    return (mRamBank % RAM_BANKS) * 8192 + (a & 16'h1FFF);
  endfunction

  function automatic int expRd(int a, bit rd, int rom, int ram);
    if (!rd) return 8'hFF;
    if (a < 16'h8000) return rom;
    if (a >= 16'hA000 && a < 16'hC000 && mOn && RAM_KB != 0) return ram;
    return 8'hFF;
  endfunction

  task automatic modelWrite(int a, int d);
    if (a < 16'h2000)      mOn = ((d & 8'h0F) == 8'h0A);
    else if (a < 16'h4000) mBank = d & 8'h7F;
    else if (a < 16'h6000) begin
      if (d <= 3) mRamBank = d;
      else        mErr = 1'b1;
    end
  endtask

  // one bus cycle: drive at the falling edge, check before the rising edge
  task automatic doOp(string tag, int a, int d, bit wr, bit rd);
    bit inRam;
    @(negedge clk);
    cpuAddr   = a[15:0];
    cpuWrData = d[7:0];
    cpuWr     = wr;
    cpuRd     = rd;
    romData   = 8'($urandom);
    ramRdData = 8'($urandom);
    #2;
    inRam = (a >= 16'hA000 && a < 16'hC000);
    if (a < 16'h8000)
      chk({tag, (a < 16'h4000) ? " R4 romAddr" : " R5 romAddr"}, int'(romAddr), expRom(a));
    if (inRam) chk({tag, " R9 ramAddr"}, int'(ramAddr), expRam(a));
    chk({tag, " R10 ramWe"}, int'(ramWe), int'(wr && inRam && mOn));
    chk({tag, (inRam && !mOn) ? " R10 rdData" : " R11 rdData"},
        int'(cpuRdData), expRd(a, rd, int'(romData), int'(ramRdData)));
    chk({tag, " R7 selErr"}, int'(selErr), int'(mErr));
    @(posedge clk);
    if (wr) modelWrite(a, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    mOn = 1'b0; mBank = 1; mRamBank = 0; mErr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state seen through the ports
    doOp("R1", 16'h4123, 0, 1'b0, 1'b1);
    doOp("R1", 16'hA010, 0, 1'b0, 1'b1);
    doOp("R1", 16'hA010, 8'h55, 1'b1, 1'b0);

    // R3 bank number corner cases
    doOp("R3", 16'h2000, 8'h00, 1'b1, 1'b0);
    doOp("R3", 16'h7FFF, 0, 1'b0, 1'b1);
    doOp("R3", 16'h3FFF, 8'h80, 1'b1, 1'b0);
    doOp("R3", 16'h4001, 0, 1'b0, 1'b1);
    doOp("R3", 16'h2100, 8'h25, 1'b1, 1'b0);
    doOp("R5", 16'h5abc, 0, 1'b0, 1'b1);
    doOp("R5", 16'h2000, 8'h20, 1'b1, 1'b0);
    doOp("R5", 16'h6000, 0, 1'b0, 1'b1);
    doOp("R4", 16'h3FFF, 0, 1'b0, 1'b1);

    // R2 enable decoding
    doOp("R2", 16'h0000, 8'hFA, 1'b1, 1'b0);
    doOp("R2", 16'hB000, 0, 1'b0, 1'b1);
    doOp("R2", 16'h1FFF, 8'h0B, 1'b1, 1'b0);
    doOp("R2", 16'hB000, 8'h12, 1'b1, 1'b1);
    doOp("R2", 16'h1000, 8'h0A, 1'b1, 1'b0);

    // R6 / R7 RAM select
    doOp("R6", 16'h4000, 8'h03, 1'b1, 1'b0);
    doOp("R6", 16'hBFFF, 8'h77, 1'b1, 1'b1);
    doOp("R7", 16'h5000, 8'h08, 1'b1, 1'b0);
    doOp("R7", 16'hA123, 0, 1'b0, 1'b1);
    doOp("R7", 16'h4000, 8'h01, 1'b1, 1'b0);
    doOp("R7", 16'hA123, 0, 1'b0, 1'b1);

    // R8 latch region leaves everything alone
    doOp("R8", 16'h6000, 8'h00, 1'b1, 1'b0);
    doOp("R8", 16'h7FFF, 8'h01, 1'b1, 1'b0);
    doOp("R8", 16'h4567, 0, 1'b0, 1'b1);
    doOp("R8", 16'hA000, 0, 1'b0, 1'b1);

    // R11 outside both windows
    doOp("R11", 16'h8000, 0, 1'b0, 1'b1);
    doOp("R11", 16'hC000, 0, 1'b0, 1'b1);
    doOp("R11", 16'h1234, 0, 1'b0, 1'b0);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int r;
      int a;
      int d;
      bit wr;
      r  = int'($urandom % 8);
      d  = int'($urandom % 256);
      wr = 1'b0;
      case (r)
        0: begin a = int'($urandom % 16'h2000); wr = 1'b1;
                 if ($urandom % 2 == 0) d = (d & 8'hF0) | 8'h0A; end
        1: begin a = 16'h2000 + int'($urandom % 16'h2000); wr = 1'b1; end
        2: begin a = 16'h4000 + int'($urandom % 16'h2000); wr = 1'b1;
                 if ($urandom % 8 != 0) d = int'($urandom % 4); end
        3: begin a = 16'h6000 + int'($urandom % 16'h2000); wr = 1'b1; end
        4: a = int'($urandom % 16'h4000);
        5: a = 16'h4000 + int'($urandom % 16'h4000);
        6: begin a = 16'hA000 + int'($urandom % 16'h2000); wr = ($urandom % 2) == 1; end
        default: begin
          a = ($urandom % 2 == 0) ? 16'h8000 + int'($urandom % 16'h2000)
                                  : 16'hC000 + int'($urandom % 16'h4000);
          wr = ($urandom % 2) == 1;
        end
      endcase
      doOp("RND", a, d, wr, !wr && ($urandom % 8 != 0));
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule